// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Model

This block is a synthesizable behavioural model of a byte-wide, one-time-programmable parallel memory with a 19-bit address. Two active-low strobes (chip select and output gate) are decoded together with two boolean flags. One flag says that programming voltage is present. The other says that an identification voltage sits on address line 9. From these the block chooses one of several operations:

- array read, or verify while programming
- an identification byte
- a write that can only clear bits
- an idle state with the bus released

Analog levels are reduced to flags. Ultraviolet erasure becomes a synchronous erase input. The array stored in simulation is a parameterised power-of-two slice of the full address space, and higher address bits alias onto it.

The data bus is split into an input byte, an output byte and a drive-enable. A board-level wrapper can combine them into a tri-state pin, and a bench can observe high impedance directly. Every output is registered one clock after its inputs are sampled, which stands in for the access delay. Stored bytes start at all ones after reset or erase. A program cycle stores the bitwise AND of the old byte and the input byte.

Top module: `prom_model`

## Requirements
- R1: After reset every stored byte reads 0xFF and `dout_en` is low with `dout` at 0x00.
- R2: With `vpp_hi` low, `ce_n` low, `oe_n` low and `id_hv` low, the clock edge after the inputs are sampled shows `dout_en` high and `dout` equal to the byte stored at `addr[ARR_AW-1:0]`. Address bits above the array width are ignored.
- R3: With `vpp_hi` low and either `ce_n` or `oe_n` high, the next edge shows `dout_en` low and `dout` at 0x00, whatever the value of `id_hv`.
- R4: With `vpp_hi` high, `ce_n` low and `oe_n` high (program), each clock edge replaces the addressed byte with the old byte ANDed with `din`, and the next edge shows `dout_en` low.
- R5: A 1 in `din` never turns a stored 0 back into 1; only erase or reset can do that.
- R6: With `vpp_hi` high and `ce_n` equal to `oe_n`, nothing is written and the next edge shows `dout_en` low.
- R7: With `vpp_hi` high, `ce_n` high and `oe_n` low (verify), the next edge drives the stored byte with `dout_en` high; `id_hv` has no effect here.
- R8: In read conditions with `id_hv` high and every address bit other than bits 0 and 9 low, the next edge drives 0x97 when `addr[0]` is 0 and 0x50 when `addr[0]` is 1, instead of array data.
- R9: In read conditions with `id_hv` high and any address bit other than bits 0 and 9 set, the next edge drives 0xFF.
- R10: `erase` high at a clock edge sets every stored byte to 0xFF. It overrides a program cycle in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; array to all ones, bus released |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming voltage present |
| id_hv | input | 1 | Identification voltage on address line 9 |
| addr | input | ADDR_W (19) | Byte address |
| din | input | DATA_W (8) | Program data from the bus |
| erase | input | 1 | Synchronous erase of the whole array |
| dout | output | DATA_W (8) | Registered output data; 0 when not driving |
| dout_en | output | 1 | Registered bus drive-enable |

## Verification
Two functions can collide in one edge. Erase and a program cycle can arrive together. Separately, the identification flag can be held high during verify or program, where it must be ignored. The bench provokes the first by raising `erase` during a program cycle that writes 0x00. It then reads back that byte and the bytes programmed earlier, and expects 0xFF everywhere. It provokes the second by verifying with the flag set and expecting array data, not an identifier. A reference model in the bench tracks the array and predicts the bus on every clock.

// File: rtl/prom_pkg.sv
package prom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_QUIET   = 3'd1,
        MD_READ    = 3'd2,
        MD_IDENT   = 3'd3,
        MD_PROG    = 3'd4,
        MD_HOLD    = 3'd5,
        MD_VERIFY  = 3'd6,
        MD_CLASH   = 3'd7
    } prom_mode_e;

    localparam logic [7:0] MAKER_CODE = 8'h97;
    localparam logic [7:0] PART_CODE  = 8'h50;

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
    import prom_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       vpp_hi,
    input  logic       id_hv,
    output prom_mode_e mode
);

    always_comb begin
        mode = MD_STANDBY;
        if (!vpp_hi) begin
            if (ce_n)
                mode = MD_STANDBY;
            else if (oe_n)
                mode = MD_QUIET;
            else if (id_hv)
                mode = MD_IDENT;
            else
                mode = MD_READ;
        end else begin
            case ({ce_n, oe_n})
                2'b01:   mode = MD_PROG;
                2'b11:   mode = MD_HOLD;
                2'b10:   mode = MD_VERIFY;
                default: mode = MD_CLASH;
            endcase
        end
    end

endmodule

// File: rtl/prom_id_sel.sv
module prom_id_sel #(
    parameter int          ADDR_W  = 19,
    parameter int          DATA_W  = 8,
    parameter int          HV_BIT  = 9,
    parameter logic [7:0]  LO_CODE = 8'h97,
    parameter logic [7:0]  HI_CODE = 8'h50
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] id_byte
);

    localparam logic [ADDR_W-1:0] SEL_BITS   = ADDR_W'(1) | (ADDR_W'(1) << HV_BIT);
    localparam logic [ADDR_W-1:0] OTHER_BITS = ~SEL_BITS;

    logic stray;

    assign stray = |(addr & OTHER_BITS);

    always_comb begin
        if (stray)
            id_byte = '1;
        else if (addr[0])
            id_byte = DATA_W'(HI_CODE);
        else
            id_byte = DATA_W'(LO_CODE);
    end

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
    parameter int ARR_AW = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ARR_AW-1:0] cell_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] byte_d;
        logic              hit;

        assign hit = wr_en && (cell_addr == ARR_AW'(g));

        always_comb begin
            byte_d = cell_q[g];
            if (erase)
                byte_d = '1;
            else if (hit)
                byte_d = cell_q[g] & wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q[g] <= '1;
            else
                cell_q[g] <= byte_d;
        end
    end

    assign rd_data = cell_q[cell_addr];

endmodule

// File: rtl/prom_model.sv
module prom_model
    import prom_pkg::*;
#(
    parameter int         ADDR_W  = 19,
    parameter int         DATA_W  = 8,
    parameter int         ARR_AW  = 6,
    parameter int         HV_BIT  = 9,
    parameter logic [7:0] LO_CODE = MAKER_CODE,
    parameter logic [7:0] HI_CODE = PART_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } bus_t;

    prom_mode_e        mode;
    logic [DATA_W-1:0] cell_byte;
    logic [DATA_W-1:0] id_byte;
    logic              prog_pulse;
    bus_t              bus_d, bus_q;

    prom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .mode   (mode)
    );

    prom_id_sel #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HV_BIT  (HV_BIT),
        .LO_CODE (LO_CODE),
        .HI_CODE (HI_CODE)
    ) u_id (
        .addr    (addr),
        .id_byte (id_byte)
    );

    assign prog_pulse = (mode == MD_PROG);

    prom_cell_array #(
        .ARR_AW (ARR_AW),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase     (erase),
        .wr_en     (prog_pulse),
        .cell_addr (addr[ARR_AW-1:0]),
        .wr_data   (din),
        .rd_data   (cell_byte)
    );

    always_comb begin
        bus_d = '0;
        case (mode)
            MD_READ, MD_VERIFY: begin
                bus_d.drive = 1'b1;
                bus_d.data  = cell_byte;
            end
            MD_IDENT: begin
                bus_d.drive = 1'b1;
                bus_d.data  = id_byte;
            end
            default: bus_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_q <= '0;
        else
            bus_q <= bus_d;
    end

    assign dout    = bus_q.data;
    assign dout_en = bus_q.drive;

endmodule

// File: rtl/prom_model_chk.sv
module prom_model_chk #(
    parameter int         ADDR_W  = 19,
    parameter int         DATA_W  = 8,
    parameter int         HV_BIT  = 9,
    parameter logic [7:0] LO_CODE = 8'h97,
    parameter logic [7:0] HI_CODE = 8'h50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    localparam logic [ADDR_W-1:0] OTHERS = ~(ADDR_W'(1) | (ADDR_W'(1) << HV_BIT));

    logic rd_cond;
    logic id_clean;

    assign rd_cond  = !vpp_hi && !ce_n && !oe_n;
    assign id_clean = (addr & OTHERS) == '0;

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cond && !id_hv) |=> dout_en);

    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && (ce_n || oe_n)) |=> (!dout_en && dout == '0));

    a_r4_prog_released: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !ce_n && oe_n) |=> !dout_en);

    a_r6_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && (ce_n == oe_n)) |=> !dout_en);

    a_r7_verify_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && ce_n && !oe_n) |=> dout_en);

    a_r8_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cond && id_hv && id_clean && !addr[0]) |=> (dout_en && dout == DATA_W'(LO_CODE)));

    a_r8_part_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cond && id_hv && id_clean && addr[0]) |=> (dout_en && dout == DATA_W'(HI_CODE)));

    a_r9_stray_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cond && id_hv && !id_clean) |=> (dout_en && dout == '1));

endmodule

bind prom_model prom_model_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HV_BIT  (HV_BIT),
    .LO_CODE (LO_CODE),
    .HI_CODE (HI_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .id_hv   (id_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/sim_prom_model.sv
module sim_prom_model;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 19;
    localparam int DW    = 8;
    localparam int MAW   = 6;
    localparam int DEPTH = 1 << MAW;
    localparam int LIMIT = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          vpp_hi = 1'b0;
    logic          id_hv = 1'b0;
    logic          erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    string note = "";
    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    done = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic          exp_en = 1'b0;
    logic [DW-1:0] exp_data = '0;
    string         exp_tag = "R1";
    bit            cmp_ok = 0;

    prom_model u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_hi  (vpp_hi),
        .id_hv   (id_hv),
        .addr    (addr),
        .din     (din),
        .erase   (erase),
        .dout    (dout),
        .dout_en (dout_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: predicts the bus one edge ahead and tracks the array.
    always @(posedge clk) begin
        string t;
        int    idx;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            exp_en   = 1'b0;
            exp_data = '0;
            exp_tag  = "R1";
            cmp_ok   = 1;
        end else begin
            idx      = int'(addr) % DEPTH;
            exp_en   = 1'b0;
            exp_data = '0;
            if (!vpp_hi) begin
                if (!ce_n && !oe_n) begin
                    exp_en = 1'b1;
                    if (id_hv) begin
                        if ((addr & ~19'h00201) != 0) begin
                            exp_data = 8'hFF;
                            t = "R9";
                        end else begin
                            exp_data = addr[0] ? 8'h50 : 8'h97;
                            t = "R8";
                        end
                    end else begin
                        exp_data = ref_mem[idx];
                        t = "R2";
                    end
                end else begin
                    t = "R3";
                end
            end else begin
                if (ce_n && !oe_n) begin
                    exp_en   = 1'b1;
                    exp_data = ref_mem[idx];
                    t = "R7";
                end else if (!ce_n && oe_n) begin
                    t = "R4";
                end else begin
                    t = "R6";
                end
            end
            if (note != "") t = note;
            exp_tag = t;
            if (erase) begin
                for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            end else if (vpp_hi && !ce_n && oe_n) begin
                ref_mem[idx] = ref_mem[idx] & din;
            end
            cmp_ok = 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_ok && !done) begin
            checks++;
            if (dout_en !== exp_en || dout !== exp_data) begin
                fails++;
                $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
                         exp_tag, dout_en, dout, exp_en, exp_data);
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= LIMIT && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, LIMIT);
            finish_up();
        end
    end

    task automatic step(input logic c, input logic o, input logic v, input logic h,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic e, input string n);
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_hi = v; id_hv = h;
        addr = a; din = d; erase = e; note = n;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string n);
        step(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b0, n);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input string n);
        step(1'b0, 1'b1, 1'b1, 1'b0, a, d, 1'b0, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: released bus and an all-ones array after reset
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, "R1");
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R1");

        // R4: program pulses (bus released while programming)
        prog(19'd5,  8'hA5, "R4");
        prog(19'd6,  8'h3C, "R4");
        prog(19'd63, 8'h0F, "R4");
        prog(19'd63, 8'h0F, "R4");

        // R2: read back, including aliased upper address bits
        rd(19'd5, "R2");
        rd(19'd6, "R2");
        rd(19'h40000 | 19'd63, "R2");
        rd(19'h00400 | 19'd6, "R2");

        // R5: ones in the input cannot set cleared bits
        prog(19'd5, 8'hFF, "R5");
        rd(19'd5, "R5");
        prog(19'd5, 8'hF0, "R5");
        rd(19'd5, "R5");

        // R3: standby and output-off, with the id flag set too
        step(1'b1, 1'b0, 1'b0, 1'b1, 19'd5, 8'h00, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b0, 1'b1, 19'd0, 8'h00, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, 1'b0, 19'd6, 8'h00, 1'b0, "R3");

        // R6: inhibit and the clash state write nothing
        step(1'b1, 1'b1, 1'b1, 1'b0, 19'd6, 8'h00, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, 19'd6, 8'h00, 1'b0, "R6");
        rd(19'd6, "R6");

        // R7: verify drives array data even with the id flag high
        step(1'b1, 1'b0, 1'b1, 1'b0, 19'd63, 8'h00, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b1, 19'd0, 8'h00, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b1, 19'd5, 8'h00, 1'b0, "R7");

        // R8: identifier bytes, bit 9 itself does not disturb them
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h00000, 8'h00, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h00001, 8'h00, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h00200, 8'h00, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h00201, 8'h00, 1'b0, "R8");

        // R9: stray address bits under the id flag
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h00004, 8'h00, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h40001, 8'h00, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 19'h00400, 8'h00, 1'b0, "R9");

        // R10: erase in the same edge as a program of 0x00
        prog(19'd7, 8'h00, "R10");
        step(1'b0, 1'b1, 1'b1, 1'b0, 19'd7, 8'h00, 1'b1, "R10");
        rd(19'd7, "R10");
        rd(19'd5, "R10");
        rd(19'd6, "R10");
        rd(19'd63, "R10");

        // program again after erase
        prog(19'd7, 8'h81, "R4");
        rd(19'd7, "R2");

        repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, "R3");
        @(negedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule